// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor core that runs one instruction per clock. It implements ten instructions of a 32-bit load/store instruction set: add, sub, and, or, slt, ori, lw, sw, beq and j. In the cycle an instruction is fetched, the core decodes it, reads its operands, computes its result and chooses the next program counter. The register file write, the data memory write and the PC update all take effect on the next rising edge.

Instruction storage and data storage are separate internal word arrays. Before a program runs, the environment fills them through a load port while reset is held. Every commit the core makes is shown on a set of event outputs: register writes, data memory writes and the current PC. A surrounding checker can trace execution from these without looking inside the core.

Control is split into two stages. A main decoder turns the opcode into steering and write-enable signals plus a 2-bit ALU class. A second stage combines that class with the function field to pick the ALU operation.

Top module: `mono_cycle_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0. During reset `rf_we_o` and `dm_we_o` stay low.
- R2: Any instruction other than j or a taken beq moves the PC to PC+4, including beq with unequal operands.
- R3: Opcode 0x00 is register-to-register and writes register rd (bits 15:11) with the result of rs (bits 25:21) and rt (bits 20:16). Function codes: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A set-if-less-than (signed, result 1 or 0).
- R4: ori (opcode 0x0D) writes register rt with rs OR the zero-extended imm16 (bits 15:0).
- R5: lw (opcode 0x23) writes register rt with the data word at byte address rs + sign-extended imm16.
- R6: sw (opcode 0x2B) writes rt to data memory at byte address rs + sign-extended imm16. It makes no register write.
- R7: beq (opcode 0x04) with equal rs and rt sets the PC to (PC+4) + (sign-extended imm16 × 4). This covers backward targets.
- R8: j (opcode 0x02) sets the PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R9: Any other opcode makes neither a register write nor a memory write, and advances the PC by 4.
- R10: Register 0 reads as zero. A write aimed at it produces no write event and does not change it.
- R11: When `ld_en` is high at a rising edge, `ld_data` is stored at word `ld_addr`. It goes into data memory when `ld_dmem` is 1 and into instruction memory otherwise. Instruction and data word n sit at byte address 4n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load port write strobe |
| ld_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| ld_addr | input | LD_AW (6) | Word index for the load port |
| ld_data | input | DATA_W (32) | Word written through the load port |
| pc_o | output | DATA_W (32) | Current program counter |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_wa_o | output | 5 | Destination register of that write |
| rf_wd_o | output | DATA_W (32) | Value of that write |
| dm_we_o | output | 1 | A data memory write commits at the next edge |
| dm_addr_o | output | DATA_W (32) | Data byte address (ALU result) |
| dm_wd_o | output | DATA_W (32) | Store data (register rt) |

## Verification
Assertions check these on every cycle:
- the PC follows its three rules: +4, taken-branch target, and jump target;
- register-to-register results go to rd;
- stores and unknown opcodes leave the register file alone;
- a committed store lands in the addressed data word;
- register 0 reads as zero on both ports.

The scenarios are needed for the actual values: the result of each ALU function, signed comparison, zero versus sign extension, and load data that came through the load port or from an earlier store. Skipped instructions that must leave no trace after a forward branch or a jump, and the return to PC 0 from a running program, are also visible only through the event outputs over a sequence.

// File: rtl/core_pkg.sv
package core_pkg;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_JUMP  = 6'h02;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_ORI   = 6'h0D;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   // class handed from the main decoder to the ALU-control stage
   typedef enum logic [1:0] {
      CLS_ADD   = 2'b00,
      CLS_SUB   = 2'b01,
      CLS_FUNCT = 2'b10,
      CLS_OR    = 2'b11
   } alu_cls_e;

   // operation code presented to the ALU
   typedef enum logic [3:0] {
      ALU_AND = 4'b0000,
      ALU_OR  = 4'b0001,
      ALU_ADD = 4'b0010,
      ALU_SUB = 4'b0110,
      ALU_SLT = 4'b0111
   } alu_fn_e;

   typedef struct packed {
      logic     dst_rd;      // 1: write rd, 0: write rt
      logic     b_imm;       // 1: ALU B from extended immediate
      logic     wb_mem;      // 1: write back load data
      logic     reg_wr;
      logic     mem_rd;
      logic     mem_wr;
      logic     branch;
      logic     jump;
      logic     zero_ext;    // 1: zero-extend imm16
      alu_cls_e cls;
   } ctrl_t;

endpackage

// File: rtl/core_main_dec.sv
module core_main_dec
   import core_pkg::*;
(
   input  logic [5:0] opcode,
   output ctrl_t      ctl,
   output logic       known
);

   always_comb begin
      ctl   = '0;
      known = 1'b1;
      case (opcode)
         OP_RTYPE: begin
            ctl.dst_rd = 1'b1;
            ctl.reg_wr = 1'b1;
            ctl.cls    = CLS_FUNCT;
         end
         OP_ORI: begin
            ctl.b_imm    = 1'b1;
            ctl.reg_wr   = 1'b1;
            ctl.zero_ext = 1'b1;
            ctl.cls      = CLS_OR;
         end
         OP_LW: begin
            ctl.b_imm  = 1'b1;
            ctl.wb_mem = 1'b1;
            ctl.reg_wr = 1'b1;
            ctl.mem_rd = 1'b1;
            ctl.cls    = CLS_ADD;
         end
         OP_SW: begin
            ctl.b_imm  = 1'b1;
            ctl.mem_wr = 1'b1;
            ctl.cls    = CLS_ADD;
         end
         OP_BEQ: begin
            ctl.branch = 1'b1;
            ctl.cls    = CLS_SUB;
         end
         OP_JUMP: begin
            ctl.jump = 1'b1;
         end
         default: known = 1'b0;
      endcase
   end

endmodule

// File: rtl/core_alu.sv
module core_alu
   import core_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_cls_e     cls,
   input  logic [5:0]   funct,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y,
   output logic         zero
);

   alu_fn_e fn;

   // ALU-control stage: class from the main decoder plus funct
   always_comb begin
      case (cls)
         CLS_ADD: fn = ALU_ADD;
         CLS_SUB: fn = ALU_SUB;
         CLS_OR:  fn = ALU_OR;
         default: begin
            case (funct)
               FN_SUB:  fn = ALU_SUB;
               FN_AND:  fn = ALU_AND;
               FN_OR:   fn = ALU_OR;
               FN_SLT:  fn = ALU_SLT;
               default: fn = ALU_ADD;
            endcase
         end
      endcase
   end

   always_comb begin
      case (fn)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SUB: y = a - b;
         ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
   parameter int W = 32,
   parameter int N = 32,
   localparam int AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra_a,
   input  logic [AW-1:0] ra_b,
   output logic [W-1:0]  rd_a,
   output logic [W-1:0]  rd_b
);

   logic [W-1:0] regs [N];

   // entry 0 is a constant; only 1..N-1 hold state
   generate
      for (genvar i = 0; i < N; i++) begin : g_ent
         if (i == 0) begin : g_zero
            assign regs[i] = '0;
         end else begin : g_store
            always_ff @(posedge clk) begin
               if (we && wa == AW'(i)) regs[i] <= wd;
            end
         end
      end
   endgenerate

   assign rd_a = regs[ra_a];
   assign rd_b = regs[ra_b];

   // R10
   r0_port_a_chk: assert property (@(posedge clk) disable iff (rst)
      (ra_a == '0) |-> (rd_a == '0));
   // R10
   r0_port_b_chk: assert property (@(posedge clk) disable iff (rst)
      (ra_b == '0) |-> (rd_b == '0));

endmodule

// File: rtl/mono_cycle_core.sv
module mono_cycle_core
   import core_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NREG       = 32,
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64,
   localparam int IM_AW = $clog2(IMEM_WORDS),
   localparam int DM_AW = $clog2(DMEM_WORDS),
   localparam int LD_AW = (IM_AW > DM_AW) ? IM_AW : DM_AW,
   localparam int RA_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_en,
   input  logic              ld_dmem,
   input  logic [LD_AW-1:0]  ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   output logic [DATA_W-1:0] pc_o,
   output logic              rf_we_o,
   output logic [RA_W-1:0]   rf_wa_o,
   output logic [DATA_W-1:0] rf_wd_o,
   output logic              dm_we_o,
   output logic [DATA_W-1:0] dm_addr_o,
   output logic [DATA_W-1:0] dm_wd_o
);

   // elaboration-time parameter checks
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("mono_cycle_core: DATA_W must be 32");
      end
      if (NREG != 32) begin : g_bad_nreg
         $error("mono_cycle_core: NREG must match the 5-bit register fields");
      end
      if ((IMEM_WORDS & (IMEM_WORDS - 1)) != 0 || IMEM_WORDS < 2) begin : g_bad_im
         $error("mono_cycle_core: IMEM_WORDS must be a power of two");
      end
      if ((DMEM_WORDS & (DMEM_WORDS - 1)) != 0 || DMEM_WORDS < 2) begin : g_bad_dm
         $error("mono_cycle_core: DMEM_WORDS must be a power of two");
      end
   endgenerate

   logic [DATA_W-1:0] pc_q, pc4, pc_nxt, br_tgt, jmp_tgt;
   logic [DATA_W-1:0] imem_q [IMEM_WORDS];
   logic [DATA_W-1:0] dmem_q [DMEM_WORDS];
   logic [DATA_W-1:0] instr;

   logic [5:0]        op, funct;
   logic [RA_W-1:0]   rs, rt, rd, wa;
   logic [15:0]       imm;
   logic [25:0]       tgt;
   logic [4:0]        unused_shamt;

   ctrl_t             ctl;
   logic              known;
   logic [DATA_W-1:0] ext, rs_val, rt_val, alu_b, alu_y, dm_rdata, wd;
   logic              alu_zero, take_br, rf_we, dm_we;
   logic [IM_AW-1:0]  im_idx;
   logic [DM_AW-1:0]  dm_idx;

   // fetch
   assign im_idx = pc_q[IM_AW+1:2];
   assign instr  = imem_q[im_idx];

   assign op           = instr[31:26];
   assign rs           = instr[25:21];
   assign rt           = instr[20:16];
   assign rd           = instr[15:11];
   assign unused_shamt = instr[10:6];
   assign funct        = instr[5:0];
   assign imm          = instr[15:0];
   assign tgt          = instr[25:0];

   core_main_dec u_dec (
      .opcode (op),
      .ctl    (ctl),
      .known  (known)
   );

   assign ext = ctl.zero_ext ? {{(DATA_W-16){1'b0}}, imm}
                             : {{(DATA_W-16){imm[15]}}, imm};

   core_regfile #(.W(DATA_W), .N(NREG)) u_rf (
      .clk  (clk),
      .rst  (rst),
      .we   (rf_we),
      .wa   (wa),
      .wd   (wd),
      .ra_a (rs),
      .ra_b (rt),
      .rd_a (rs_val),
      .rd_b (rt_val)
   );

   assign alu_b = ctl.b_imm ? ext : rt_val;

   core_alu #(.W(DATA_W)) u_alu (
      .cls   (ctl.cls),
      .funct (funct),
      .a     (rs_val),
      .b     (alu_b),
      .y     (alu_y),
      .zero  (alu_zero)
   );

   // data memory: combinational read, edge write
   assign dm_idx   = alu_y[DM_AW+1:2];
   assign dm_rdata = dmem_q[dm_idx];
   assign dm_we    = ctl.mem_wr && !rst;

   always_ff @(posedge clk) begin
      if (ld_en && ld_dmem) dmem_q[ld_addr[DM_AW-1:0]] <= ld_data;
      else if (dm_we)       dmem_q[dm_idx] <= rt_val;
   end

   always_ff @(posedge clk) begin
      if (ld_en && !ld_dmem) imem_q[ld_addr[IM_AW-1:0]] <= ld_data;
   end

   // write-back steering
   assign wa    = ctl.dst_rd ? rd : rt;
   assign wd    = (ctl.wb_mem && ctl.mem_rd) ? dm_rdata : alu_y;
   assign rf_we = ctl.reg_wr && !rst && (wa != '0);

   // next PC: separate adders for the sequential and branch targets
   assign pc4     = pc_q + DATA_W'(4);
   assign br_tgt  = pc4 + {ext[DATA_W-3:0], 2'b00};
   assign jmp_tgt = {pc4[DATA_W-1:28], tgt, 2'b00};
   assign take_br = ctl.branch && alu_zero;

   always_comb begin
      if (ctl.jump)     pc_nxt = jmp_tgt;
      else if (take_br) pc_nxt = br_tgt;
      else              pc_nxt = pc4;
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_nxt;
   end

   assign pc_o      = pc_q;
   assign rf_we_o   = rf_we;
   assign rf_wa_o   = wa;
   assign rf_wd_o   = wd;
   assign dm_we_o   = dm_we;
   assign dm_addr_o = alu_y;
   assign dm_wd_o   = rt_val;

   // R1
   pc_rst_chk: assert property (@(posedge clk)
      rst |=> (pc_q == '0));
   // R1
   rst_quiet_chk: assert property (@(posedge clk)
      rst |-> (!rf_we_o && !dm_we_o));
   // R2
   pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
      (!ctl.jump && !(ctl.branch && rs_val == rt_val))
      |=> (pc_q == $past(pc_q) + DATA_W'(4)));
   // R7
   br_take_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_BEQ && rs_val == rt_val)
      |=> (pc_q == $past(pc_q) + DATA_W'(4)
                   + $past({{(DATA_W-18){instr[15]}}, instr[15:0], 2'b00})));
   // R8
   jump_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_JUMP) |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));
   // R3
   rtype_dst_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_RTYPE && rf_we_o) |-> (rf_wa_o == instr[15:11]));
   // R6
   sw_no_reg_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_SW) |-> !rf_we_o);
   // R9
   unk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !known |-> (!rf_we_o && !dm_we_o));
   // R6
   store_land_chk: assert property (@(posedge clk) disable iff (rst)
      (dm_we_o && !ld_en) |=> (dmem_q[$past(dm_idx)] == $past(dm_wd_o)));
   // R2
   ctl_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctl.reg_wr, ctl.mem_wr, ctl.branch, ctl.jump}));

endmodule

// File: tb/mono_cycle_core_test.sv
module mono_cycle_core_test;

   logic        clk = 1'b0;
   logic        rst, ld_en, ld_dmem;
   logic [5:0]  ld_addr;
   logic [31:0] ld_data;
   logic [31:0] pc_o, rf_wd_o, dm_addr_o, dm_wd_o;
   logic [4:0]  rf_wa_o;
   logic        rf_we_o, dm_we_o;

   always #5 clk = ~clk;

   mono_cycle_core uut (
      .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
      .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
      .rf_we_o(rf_we_o), .rf_wa_o(rf_wa_o), .rf_wd_o(rf_wd_o),
      .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wd_o(dm_wd_o)
   );

   typedef struct {
      logic [31:0] pc;
      bit          rf;
      logic [4:0]  ra;
      logic [31:0] rd;
      bit          dm;
      logic [31:0] da;
      logic [31:0] dd;
      string       tag;
   } exp_t;

   exp_t sbq[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   running = 0;
   bit   done = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                         input logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                         input int rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction
   function automatic logic [31:0] enc_j(input logic [25:0] t);
      return {6'h02, t};
   endfunction

   task automatic load(input bit to_dm, input int a, input logic [31:0] w);
      ld_en = 1'b1; ld_dmem = to_dm; ld_addr = 6'(a); ld_data = w;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic push(input logic [31:0] pc, input bit rf, input int ra,
                       input logic [31:0] rd, input bit dm, input logic [31:0] da,
                       input logic [31:0] dd, input string tag);
      exp_t e;
      e.pc = pc; e.rf = rf; e.ra = 5'(ra); e.rd = rd;
      e.dm = dm; e.da = da; e.dd = dd; e.tag = tag;
      sbq.push_back(e);
   endtask

   // monitor: one expected item per executed instruction
   always @(negedge clk) begin
      if (running) begin
         if (sbq.size() == 0) begin
            running = 0;
            done = 1;
         end else begin
            exp_t e;
            e = sbq.pop_front();
            chk(pc_o == e.pc, e.tag, "pc", pc_o, e.pc);
            chk(rf_we_o == e.rf, e.tag, "reg write flag", 32'(rf_we_o), 32'(e.rf));
            if (e.rf && rf_we_o) begin
               chk(rf_wa_o == e.ra, e.tag, "reg dest", 32'(rf_wa_o), 32'(e.ra));
               chk(rf_wd_o == e.rd, e.tag, "reg data", rf_wd_o, e.rd);
            end
            chk(dm_we_o == e.dm, e.tag, "mem write flag", 32'(dm_we_o), 32'(e.dm));
            if (e.dm && dm_we_o) begin
               chk(dm_addr_o == e.da, e.tag, "mem addr", dm_addr_o, e.da);
               chk(dm_wd_o == e.dd, e.tag, "mem data", dm_wd_o, e.dd);
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst = 1'b1; ld_en = 1'b0; ld_dmem = 1'b0; ld_addr = '0; ld_data = '0;
      repeat (2) @(negedge clk);

      // R11: program and data through the load port
      load(0, 0,  enc_i(6'h0D, 0, 1, 16'h0010));     // ori r1,r0,0x10
      load(0, 1,  enc_i(6'h23, 1, 2, 16'h0000));     // lw r2,0(r1)
      load(0, 2,  enc_i(6'h23, 1, 3, 16'h0004));     // lw r3,4(r1)
      load(0, 3,  enc_i(6'h0D, 0, 4, 16'h8005));     // ori r4,r0,0x8005
      load(0, 4,  enc_r(3, 4, 5, 6'h20));            // add r5,r3,r4
      load(0, 5,  enc_r(4, 3, 6, 6'h22));            // sub r6,r4,r3
      load(0, 6,  enc_r(2, 4, 7, 6'h24));            // and r7,r2,r4
      load(0, 7,  enc_r(1, 4, 8, 6'h25));            // or  r8,r1,r4
      load(0, 8,  enc_r(3, 4, 9, 6'h2A));            // slt r9,r3,r4
      load(0, 9,  enc_r(4, 3, 10, 6'h2A));           // slt r10,r4,r3
      load(0, 10, enc_i(6'h2B, 1, 5, 16'hFFF8));     // sw r5,-8(r1)
      load(0, 11, enc_r(1, 1, 0, 6'h20));            // add r0,r1,r1
      load(0, 12, enc_r(0, 1, 11, 6'h20));           // add r11,r0,r1
      load(0, 13, enc_i(6'h04, 1, 11, 16'h0002));    // beq r1,r11,+2
      load(0, 14, enc_i(6'h0D, 0, 12, 16'h0BAD));    // skipped
      load(0, 15, enc_i(6'h0D, 0, 12, 16'h0BAD));    // skipped
      load(0, 16, enc_i(6'h04, 1, 2, 16'h0005));     // beq r1,r2 (not taken)
      load(0, 17, enc_j(26'h14));                    // j 0x50
      load(0, 18, enc_i(6'h0D, 0, 14, 16'h0BAD));    // skipped
      load(0, 19, enc_i(6'h0D, 0, 14, 16'h0BAD));    // skipped
      load(0, 20, enc_i(6'h2B, 0, 2, 16'h0000));     // sw r2,0(r0)
      load(0, 21, {6'h3F, 5'd1, 5'd2, 16'h1234});    // unknown opcode
      load(0, 22, enc_i(6'h23, 0, 13, 16'h0008));    // lw r13,8(r0)
      load(0, 23, enc_i(6'h04, 0, 0, 16'hFFFF));     // beq r0,r0,-1
      load(1, 4,  32'hCAFEF00D);
      load(1, 5,  32'hFFFFFFF9);

      push(32'h00, 1, 1,  32'h00000010, 0, 0, 0, "R4 ori");
      push(32'h04, 1, 2,  32'hCAFEF00D, 0, 0, 0, "R5 R11 lw preload");
      push(32'h08, 1, 3,  32'hFFFFFFF9, 0, 0, 0, "R5 lw offset");
      push(32'h0C, 1, 4,  32'h00008005, 0, 0, 0, "R4 zero extend");
      push(32'h10, 1, 5,  32'h00007FFE, 0, 0, 0, "R3 add");
      push(32'h14, 1, 6,  32'h0000800C, 0, 0, 0, "R3 sub");
      push(32'h18, 1, 7,  32'h00008005, 0, 0, 0, "R3 and");
      push(32'h1C, 1, 8,  32'h00008015, 0, 0, 0, "R3 or");
      push(32'h20, 1, 9,  32'h00000001, 0, 0, 0, "R3 slt signed true");
      push(32'h24, 1, 10, 32'h00000000, 0, 0, 0, "R3 slt false");
      push(32'h28, 0, 0,  0, 1, 32'h00000008, 32'h00007FFE, "R6 sw negative offset");
      push(32'h2C, 0, 0,  0, 0, 0, 0, "R10 write to r0");
      push(32'h30, 1, 11, 32'h00000010, 0, 0, 0, "R10 r0 reads zero");
      push(32'h34, 0, 0,  0, 0, 0, 0, "R7 beq forward");
      push(32'h40, 0, 0,  0, 0, 0, 0, "R2 beq not taken");
      push(32'h44, 0, 0,  0, 0, 0, 0, "R8 jump");
      push(32'h50, 0, 0,  0, 1, 32'h00000000, 32'hCAFEF00D, "R6 R8 sw after jump");
      push(32'h54, 0, 0,  0, 0, 0, 0, "R9 unknown opcode");
      push(32'h58, 1, 13, 32'h00007FFE, 0, 0, 0, "R5 R9 lw of stored word");
      push(32'h5C, 0, 0,  0, 0, 0, 0, "R2 R7 backward beq");
      push(32'h5C, 0, 0,  0, 0, 0, 0, "R7 beq loop");
      push(32'h5C, 0, 0,  0, 0, 0, 0, "R7 beq loop");

      // R1: reset state with an instruction present
      chk(pc_o == 32'h0, "R1", "reset pc", pc_o, 32'h0);
      chk(!rf_we_o && !dm_we_o, "R1", "writes in reset",
          32'({rf_we_o, dm_we_o}), 32'h0);

      @(posedge clk);
      #1 rst = 1'b0;
      running = 1;
      wait (done);

      // R1: reset from a running program
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(pc_o == 32'h0, "R1", "pc after mid-run reset", pc_o, 32'h0);
      chk(!rf_we_o && !dm_we_o, "R1", "writes after mid-run reset",
          32'({rf_we_o, dm_we_o}), 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule